// File: doc/BRIEF.md
# Multithreaded Vertex Shader Issue Controller

This block fetches and issues instruction words for a small vertex shader core with three hardware thread contexts. Each context holds a program counter into a shared 512-entry instruction RAM. The RAM has no tags, so every fetch returns data in a fixed time. Every stored word is 123 bits wide. It pairs a scalar operation with a vector operation, and both leave the block together as one issue. The arithmetic datapaths, register files, constant storage and texture unit sit outside this block. The issued operand field carries their register selects unchanged: 128-bit four-component sources taken from input, temporary or constant storage.

A thread that issues a texture sample in its vector slot is parked. The block raises a request tagged with the thread number, and the thread stays off the issue rotation until a response with that number comes back. Meanwhile the other ready contexts share the issue slot in round-robin order, which hides the fetch latency. When no context can issue, an empty cycle goes out. A word with the end flag set completes its thread: a one-cycle done pulse is raised, and the context goes back to the free pool for the next launch.

Top module: `vtx_issue_top`

## Requirements
- R1: While reset is asserted and after it is released, with no launch, issueValid, texReqValid and every threadDone bit stay low.
- R2: A launch is accepted (launchAccept high in the same cycle as launchValid) only while a context is free. It takes the lowest-numbered free context, reported on launchTid. With all three busy, launchAccept stays low.
- R3: Each instruction is read from the RAM at the thread's program counter and appears on the issue outputs the cycle after the thread is picked. The outputs carry issueTid and issuePc. A lone ready thread issues consecutive addresses on consecutive cycles.
- R4: Word layout: bit 122 is the end flag, bits 121:116 the vector opcode, bits 115:110 the scalar opcode, bits 109:0 the operand field. Each field is presented unchanged on issueLast, issueVecOp, issueSclOp and issueOperands.
- R5: A word whose vector opcode equals 6'h2A (texture sample) raises texReqValid with texReqTid equal to the issuing thread. That thread issues nothing more until it receives a response.
- R6: The value 6'h2A in the scalar opcode field is not a texture sample. No request is raised and the thread keeps issuing.
- R7: A response (texRspValid with texRspTid) for a parked thread returns it to the rotation. Its next word, at the address after the sample, issues two cycles after the response cycle. A response for a thread that is not parked has no effect.
- R8: Ready threads are picked round-robin, starting after the last picked thread. With three threads ready, issue order is 0,1,2,0,1,2.
- R9: When no thread is ready, issueValid is low for that cycle.
- R10: A word with the end flag set is issued together with a one-cycle pulse on threadDone at the thread's bit. The thread issues nothing more, and its context becomes free for a new launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| imemWe | input | 1 | Instruction RAM write enable |
| imemWaddr | input | 9 | Instruction RAM write address |
| imemWdata | input | 123 | Instruction word to write |
| launchValid | input | 1 | Request to start a thread |
| launchPc | input | 9 | Start address of the launched thread |
| launchAccept | output | 1 | Launch taken this cycle |
| launchTid | output | 2 | Context given to the launch |
| issueValid | output | 1 | An instruction word is issued this cycle |
| issueTid | output | 2 | Thread of the issued word |
| issuePc | output | 9 | Address of the issued word |
| issueSclOp | output | 6 | Scalar slot opcode |
| issueVecOp | output | 6 | Vector slot opcode |
| issueOperands | output | 110 | Operand and register select field |
| issueLast | output | 1 | End flag of the issued word |
| texReqValid | output | 1 | Texture sample request |
| texReqTid | output | 2 | Thread that issued the sample |
| texRspValid | input | 1 | Texture response arrives |
| texRspTid | input | 2 | Thread the response belongs to |
| threadDone | output | 3 | One pulse bit per context on program end |

## Verification
Assertions check several rules on every cycle. A sampled vector-slot texture parks its thread in the next cycle, and a response wakes a parked thread. An end word frees its context, and at most one done bit is high at a time. A launch yields a ready context. A pick shows up on the issue outputs one cycle later with the same thread and address, and nothing is picked when no thread is ready. Three ready threads never see the same thread picked twice in a row. Only the bench's scenarios can show the actual instruction stream. That covers the word contents matching the RAM, the exact resume cycle after a response, the full 0,1,2 rotation, and the scalar-slot 6'h2A code not parking. The scenarios also cover bubbles while every thread waits, a response to a free context having no effect, and the reuse of a freed context.

// File: rtl/vtx_issue_pkg.sv
package vtx_issue_pkg;
  localparam int CTX_N      = 3;
  localparam int TID_W      = (CTX_N > 1) ? $clog2(CTX_N) : 1;
  localparam int IMEM_DEPTH = 512;
  localparam int PC_W       = $clog2(IMEM_DEPTH);
  localparam int WORD_W     = 123;
  localparam int OP_W       = 6;
  localparam int OPND_W     = WORD_W - 1 - 2 * OP_W;
  localparam int LAST_BIT   = WORD_W - 1;
  localparam int VOP_LSB    = LAST_BIT - OP_W;
  localparam int SOP_LSB    = VOP_LSB - OP_W;
  localparam logic [OP_W-1:0] VOP_TEX = OP_W'(42);

  typedef enum logic [1:0] {
    CTX_FREE  = 2'd0,
    CTX_READY = 2'd1,
    CTX_WAIT  = 2'd2
  } ctxState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic             rdEn;
    logic [TID_W-1:0] tid;
    logic [PC_W-1:0]  pc;
  } fetchCmd_t;

  // datapath -> control decode flags
  typedef struct packed {
    logic             valid;
    logic [TID_W-1:0] tid;
    logic             isTex;
    logic             isLast;
  } decInfo_t;
endpackage

// File: rtl/vtx_issue_rr.sv
module vtx_issue_rr #(
  parameter int N     = 3,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [N-1:0]     req,
  output logic             grantValid,
  output logic [IDX_W-1:0] grantIdx,
  output logic [N-1:0]     grantOH
);
  logic [IDX_W-1:0] lastIdx;

  always_comb begin
    int cand;
    logic [IDX_W-1:0] candIdx;
    grantValid = 1'b0;
    grantIdx   = '0;
    grantOH    = '0;
    for (int k = 1; k <= N; k++) begin
      cand = int'(lastIdx) + k;
      if (cand >= N) cand = cand - N;
      candIdx = IDX_W'(cand);
      if (!grantValid && req[candIdx]) begin
        grantValid       = 1'b1;
        grantIdx         = candIdx;
        grantOH[candIdx] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastIdx <= IDX_W'(N - 1);
    else if (grantValid) lastIdx <= grantIdx;
  end

  // R8: a single grant per cycle
  p_rr_onehot_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantOH));

  // R8: with every requester active, the previous winner is passed over
  p_rr_rotate_r8: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid ##1 (&req)) |-> (grantIdx != $past(grantIdx)));
endmodule

// File: rtl/vtx_issue_dp.sv
module vtx_issue_dp
  import vtx_issue_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              imemWe,
  input  logic [PC_W-1:0]   imemWaddr,
  input  logic [WORD_W-1:0] imemWdata,
  input  fetchCmd_t         fetch,
  output decInfo_t          dec,
  output logic              issueValid,
  output logic [TID_W-1:0]  issueTid,
  output logic [PC_W-1:0]   issuePc,
  output logic [OP_W-1:0]   issueSclOp,
  output logic [OP_W-1:0]   issueVecOp,
  output logic [OPND_W-1:0] issueOperands,
  output logic              issueLast,
  output logic              texReqValid,
  output logic [TID_W-1:0]  texReqTid
);
  logic [WORD_W-1:0] imem [IMEM_DEPTH];
  logic [WORD_W-1:0] rdWord;
  logic              stgValid;
  logic [TID_W-1:0]  stgTid;
  logic [PC_W-1:0]   stgPc;

  // tagless storage: a read always returns next cycle
  always_ff @(posedge clk) begin
    if (imemWe) imem[imemWaddr] <= imemWdata;
    if (fetch.rdEn) rdWord <= imem[fetch.pc];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stgValid <= 1'b0;
      stgTid   <= '0;
      stgPc    <= '0;
    end else begin
      stgValid <= fetch.rdEn;
      if (fetch.rdEn) begin
        stgTid <= fetch.tid;
        stgPc  <= fetch.pc;
      end
    end
  end

  assign issueValid    = stgValid;
  assign issueTid      = stgTid;
  assign issuePc       = stgPc;
  assign issueLast     = rdWord[LAST_BIT];
  assign issueVecOp    = rdWord[VOP_LSB +: OP_W];
  assign issueSclOp    = rdWord[SOP_LSB +: OP_W];
  assign issueOperands = rdWord[OPND_W-1:0];

  // only the vector slot can carry a sample
  assign texReqValid = stgValid && (issueVecOp == VOP_TEX);
  assign texReqTid   = stgTid;

  assign dec.valid  = stgValid;
  assign dec.tid    = stgTid;
  assign dec.isTex  = texReqValid;
  assign dec.isLast = stgValid && issueLast;

  // R3: a pick becomes an issue of the same thread and address one cycle later
  p_fetch_to_issue_r3: assert property (@(posedge clk) disable iff (!rstN)
    fetch.rdEn |=> (issueValid && issueTid == $past(fetch.tid)
                    && issuePc == $past(fetch.pc)));

  // R9: no pick, no issue
  p_no_pick_no_issue_r9: assert property (@(posedge clk) disable iff (!rstN)
    !fetch.rdEn |=> !issueValid);
endmodule

// File: rtl/vtx_issue_ctl.sv
module vtx_issue_ctl
  import vtx_issue_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             launchValid,
  input  logic [PC_W-1:0]  launchPc,
  input  logic             texRspValid,
  input  logic [TID_W-1:0] texRspTid,
  input  decInfo_t         dec,
  output logic             launchAccept,
  output logic [TID_W-1:0] launchTid,
  output fetchCmd_t        fetch,
  output logic [CTX_N-1:0] threadDone
);
  logic [CTX_N-1:0]            freeMask;
  logic [CTX_N-1:0]            waitMask;
  logic [CTX_N-1:0]            readyMask;
  logic [CTX_N-1:0]            eligible;
  logic [CTX_N-1:0]            launchOH;
  logic [CTX_N-1:0]            grantOH;
  logic [CTX_N-1:0][PC_W-1:0]  pcVec;
  logic                        grantValid;
  logic [TID_W-1:0]            grantIdx;

  // lowest-numbered free context takes the launch
  always_comb begin
    launchTid = '0;
    for (int t = CTX_N - 1; t >= 0; t--) begin
      if (freeMask[t]) launchTid = TID_W'(t);
    end
  end
  assign launchAccept = launchValid && (|freeMask);

  for (genvar g = 0; g < CTX_N; g++) begin : g_ctx
    ctxState_e       st;
    logic [PC_W-1:0] pc;
    logic            decHit;
    logic            rspHit;

    assign decHit       = dec.valid && (dec.tid == TID_W'(g));
    assign rspHit       = texRspValid && (texRspTid == TID_W'(g));
    assign launchOH[g]  = launchAccept && (launchTid == TID_W'(g));
    assign freeMask[g]  = (st == CTX_FREE);
    assign waitMask[g]  = (st == CTX_WAIT);
    assign readyMask[g] = (st == CTX_READY);
    // a word that parks or ends the thread is in decode: keep it off the pick
    assign eligible[g]  = readyMask[g] && !(decHit && (dec.isTex || dec.isLast));
    assign threadDone[g] = decHit && dec.isLast;
    assign pcVec[g]     = pc;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        st <= CTX_FREE;
        pc <= '0;
      end else if (launchOH[g]) begin
        st <= CTX_READY;
        pc <= launchPc;
      end else begin
        if (decHit && dec.isLast)               st <= CTX_FREE;
        else if (decHit && dec.isTex)           st <= CTX_WAIT;
        else if (st == CTX_WAIT && rspHit)      st <= CTX_READY;
        if (grantOH[g]) pc <= pc + PC_W'(1);
      end
    end
  end

  vtx_issue_rr #(.N(CTX_N), .IDX_W(TID_W)) u_rr (
    .clk       (clk),
    .rstN      (rstN),
    .req       (eligible),
    .grantValid(grantValid),
    .grantIdx  (grantIdx),
    .grantOH   (grantOH)
  );

  assign fetch.rdEn = grantValid;
  assign fetch.tid  = grantIdx;
  assign fetch.pc   = pcVec[grantIdx];

  // R2: a launch leaves its context ready
  p_launch_ready_r2: assert property (@(posedge clk) disable iff (!rstN)
    launchAccept |=> readyMask[$past(launchTid)]);

  // R5: a sampled texture parks its thread
  p_park_on_tex_r5: assert property (@(posedge clk) disable iff (!rstN)
    (dec.valid && dec.isTex && !dec.isLast) |=> waitMask[$past(dec.tid)]);

  // R7: a response wakes the parked thread
  p_wake_on_rsp_r7: assert property (@(posedge clk) disable iff (!rstN)
    (texRspValid && waitMask[texRspTid] && !launchAccept) |=> readyMask[$past(texRspTid)]);

  // R9: nothing ready means nothing picked
  p_bubble_r9: assert property (@(posedge clk) disable iff (!rstN)
    (readyMask == '0) |-> !fetch.rdEn);

  // R10: an end word frees its context, one done bit at a time
  p_free_on_last_r10: assert property (@(posedge clk) disable iff (!rstN)
    (dec.valid && dec.isLast) |=> freeMask[$past(dec.tid)]);
  p_done_onehot_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(threadDone));
endmodule

// File: rtl/vtx_issue_top.sv
module vtx_issue_top
  import vtx_issue_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              imemWe,
  input  logic [PC_W-1:0]   imemWaddr,
  input  logic [WORD_W-1:0] imemWdata,
  input  logic              launchValid,
  input  logic [PC_W-1:0]   launchPc,
  output logic              launchAccept,
  output logic [TID_W-1:0]  launchTid,
  output logic              issueValid,
  output logic [TID_W-1:0]  issueTid,
  output logic [PC_W-1:0]   issuePc,
  output logic [OP_W-1:0]   issueSclOp,
  output logic [OP_W-1:0]   issueVecOp,
  output logic [OPND_W-1:0] issueOperands,
  output logic              issueLast,
  output logic              texReqValid,
  output logic [TID_W-1:0]  texReqTid,
  input  logic              texRspValid,
  input  logic [TID_W-1:0]  texRspTid,
  output logic [CTX_N-1:0]  threadDone
);
  fetchCmd_t fetch;
  decInfo_t  dec;

  vtx_issue_ctl u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .launchValid (launchValid),
    .launchPc    (launchPc),
    .texRspValid (texRspValid),
    .texRspTid   (texRspTid),
    .dec         (dec),
    .launchAccept(launchAccept),
    .launchTid   (launchTid),
    .fetch       (fetch),
    .threadDone  (threadDone)
  );

  vtx_issue_dp u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .imemWe       (imemWe),
    .imemWaddr    (imemWaddr),
    .imemWdata    (imemWdata),
    .fetch        (fetch),
    .dec          (dec),
    .issueValid   (issueValid),
    .issueTid     (issueTid),
    .issuePc      (issuePc),
    .issueSclOp   (issueSclOp),
    .issueVecOp   (issueVecOp),
    .issueOperands(issueOperands),
    .issueLast    (issueLast),
    .texReqValid  (texReqValid),
    .texReqTid    (texReqTid)
  );
endmodule

// File: tb/tb_vtx_issue_top.sv
module tb_vtx_issue_top;
  localparam int NCTX  = 3;
  localparam int LOGN  = 128;
  localparam logic [5:0] OP_TEX = 6'h2A;
  localparam logic [5:0] OP_V   = 6'h01;
  localparam logic [5:0] OP_S   = 6'h02;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rstN, imemWe, launchValid, launchAccept;
  logic [8:0]    imemWaddr, launchPc, issuePc;
  logic [122:0]  imemWdata;
  logic [1:0]    launchTid, issueTid, texReqTid, texRspTid;
  logic          issueValid, issueLast, texReqValid, texRspValid;
  logic [5:0]    issueSclOp, issueVecOp;
  logic [109:0]  issueOperands;
  logic [2:0]    threadDone;

  vtx_issue_top dut (
    .clk(clk), .rstN(rstN), .imemWe(imemWe), .imemWaddr(imemWaddr), .imemWdata(imemWdata),
    .launchValid(launchValid), .launchPc(launchPc), .launchAccept(launchAccept), .launchTid(launchTid),
    .issueValid(issueValid), .issueTid(issueTid), .issuePc(issuePc), .issueSclOp(issueSclOp),
    .issueVecOp(issueVecOp), .issueOperands(issueOperands), .issueLast(issueLast),
    .texReqValid(texReqValid), .texReqTid(texReqTid), .texRspValid(texRspValid),
    .texRspTid(texRspTid), .threadDone(threadDone)
  );

  int unsigned nChk = 0, nFail = 0;
  int cyc = 0;
  always @(posedge clk) cyc++;

  // issue log, sampled mid-cycle
  int          logN = 0;
  logic [1:0]  logTid [LOGN];
  logic [8:0]  logPc  [LOGN];
  logic [5:0]  logVop [LOGN], logSop [LOGN];
  logic [109:0] logOpnd [LOGN];
  bit          logLast [LOGN], logDone [LOGN];
  int          logCyc [LOGN];
  int          doneCnt [NCTX];
  initial for (int t = 0; t < NCTX; t++) doneCnt[t] = 0;

  always @(negedge clk) begin
    if (issueValid && logN < LOGN) begin
      logTid[logN] = issueTid;  logPc[logN] = issuePc;
      logVop[logN] = issueVecOp; logSop[logN] = issueSclOp;
      logOpnd[logN] = issueOperands; logLast[logN] = issueLast;
      logDone[logN] = threadDone[issueTid]; logCyc[logN] = cyc;
      logN++;
    end
    for (int t = 0; t < NCTX; t++) if (threadDone[t]) doneCnt[t]++;
  end

  // texture responder with programmable latency
  int   rspLat = 5;
  int   reqCnt = 0;
  int   lastReqTid = -1;
  int   dueCyc [NCTX];
  logic autoV = 1'b0, manV = 1'b0;
  logic [1:0] autoT = '0, manT = '0;
  initial for (int t = 0; t < NCTX; t++) dueCyc[t] = -1;
  always @(negedge clk) begin
    autoV = 1'b0;
    for (int t = 0; t < NCTX; t++) begin
      if (!autoV && dueCyc[t] >= 0 && cyc >= dueCyc[t]) begin
        autoV = 1'b1; autoT = 2'(t); dueCyc[t] = -1;
      end
    end
    if (texReqValid) begin
      dueCyc[texReqTid] = cyc + rspLat;
      reqCnt++;
      lastReqTid = int'(texReqTid);
    end
  end
  assign texRspValid = autoV | manV;
  assign texRspTid   = manV ? manT : autoT;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [109:0] opndOf(input int a);
    return {14'h2AAA, 32'hFACE0000 | 32'(a), 32'hBEEF0000 | 32'(a), 32'(a)};
  endfunction

  function automatic logic [122:0] mkWord(input bit last, input logic [5:0] vop,
                                          input logic [5:0] sop, input int a);
    return {last, vop, sop, opndOf(a)};
  endfunction

  task automatic loadWord(input int a, input logic [122:0] w);
    imemWe = 1'b1; imemWaddr = 9'(a); imemWdata = w;
    @(negedge clk);
    imemWe = 1'b0;
  endtask

  task automatic doLaunch(input int pc, output bit acc, output int tid);
    launchValid = 1'b1; launchPc = 9'(pc);
    #1;
    acc = launchAccept; tid = int'(launchTid);
    @(negedge clk);
    launchValid = 1'b0;
  endtask

  task automatic waitLog(input int n, input int maxCyc);
    for (int i = 0; i < maxCyc && logN < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    rstN = 1'b0; imemWe = 1'b0; launchValid = 1'b0; imemWaddr = '0; imemWdata = '0; launchPc = '0;
    repeat (3) @(negedge clk);
    check(!issueValid && !texReqValid && threadDone == 3'b000, "R1", "outputs in reset",
          {issueValid, texReqValid, threadDone}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(!issueValid && !texReqValid && threadDone == 3'b000 && logN == 0, "R1",
          "idle after reset", logN, 0);
  endtask

  task automatic t_single();
    int b, d0, tid; bit acc;
    for (int a = 16; a <= 20; a++) loadWord(a, mkWord(a == 20, OP_V, OP_S, a));
    b = logN; d0 = doneCnt[0];
    doLaunch(16, acc, tid);
    check(acc && tid == 0, "R2", "first launch gets context 0", tid, 0);
    waitLog(b + 5, 50);
    repeat (5) @(negedge clk);
    check(logN == b + 5, "R10", "issue count for 5-word program", logN - b, 5);
    for (int i = 0; i < 5; i++) begin
      check(logTid[b+i] == 0 && logPc[b+i] == 9'(16 + i), "R3", "tid/pc sequence", logPc[b+i], 16 + i);
      check(logOpnd[b+i] == opndOf(16 + i) && logVop[b+i] == OP_V && logSop[b+i] == OP_S
            && logLast[b+i] == (i == 4), "R4", "word fields", logOpnd[b+i][63:0], opndOf(16 + i) & 64'hFFFFFFFFFFFFFFFF);
      if (i > 0) check(logCyc[b+i] == logCyc[b+i-1] + 1, "R3", "back-to-back issue", logCyc[b+i] - logCyc[b+i-1], 1);
    end
    check(logDone[b+4] && doneCnt[0] == d0 + 1, "R10", "done pulse with end word", doneCnt[0] - d0, 1);
  endtask

  task automatic t_texture();
    int b, r0, tid; bit acc;
    loadWord(64, mkWord(0, OP_V, OP_S, 64));
    loadWord(65, mkWord(0, OP_TEX, OP_S, 65));
    loadWord(66, mkWord(0, OP_V, OP_S, 66));
    loadWord(67, mkWord(1, OP_V, OP_S, 67));
    rspLat = 10; b = logN; r0 = reqCnt;
    doLaunch(64, acc, tid);
    waitLog(b + 4, 80);
    repeat (3) @(negedge clk);
    check(logN == b + 4, "R5", "issue count", logN - b, 4);
    check(reqCnt == r0 + 1 && lastReqTid == 0, "R5", "one sample request from thread 0", reqCnt - r0, 1);
    check(logPc[b+2] == 9'd66, "R7", "resume address after sample", logPc[b+2], 66);
    check(logCyc[b+2] - logCyc[b+1] == rspLat + 2, "R7", "resume cycle after response",
          logCyc[b+2] - logCyc[b+1], rspLat + 2);
    check(logCyc[b+3] == logCyc[b+2] + 1, "R5", "issue continues after wake", logCyc[b+3] - logCyc[b+2], 1);
  endtask

  task automatic t_scalar_tex();
    int b, r0, tid; bit acc;
    loadWord(96, mkWord(0, OP_V, OP_TEX, 96));
    loadWord(97, mkWord(1, OP_V, OP_S, 97));
    b = logN; r0 = reqCnt;
    doLaunch(96, acc, tid);
    waitLog(b + 2, 30);
    repeat (3) @(negedge clk);
    check(reqCnt == r0, "R6", "no request for scalar-slot code", reqCnt - r0, 0);
    check(logN == b + 2 && logCyc[b+1] == logCyc[b] + 1, "R6", "thread not parked",
          logCyc[b+1] - logCyc[b], 1);
    check(logSop[b] == OP_TEX, "R4", "scalar opcode passed through", logSop[b], OP_TEX);
  endtask

  task automatic t_round_robin();
    int b, tid, d [NCTX]; bit acc;
    int base [NCTX] = '{128, 160, 192};
    for (int t = 0; t < NCTX; t++)
      for (int i = 0; i < 4; i++) loadWord(base[t] + i, mkWord(i == 3, OP_V, OP_S, base[t] + i));
    b = logN;
    for (int t = 0; t < NCTX; t++) d[t] = doneCnt[t];
    for (int t = 0; t < NCTX; t++) begin
      doLaunch(base[t], acc, tid);
      check(acc && tid == t, "R2", "lowest free context", tid, t);
    end
    launchValid = 1'b1; launchPc = 9'd16;
    #1;
    check(!launchAccept, "R2", "no launch while all busy", launchAccept, 0);
    launchValid = 1'b0;
    waitLog(b + 12, 60);
    repeat (4) @(negedge clk);
    check(logN == b + 12, "R8", "total issues", logN - b, 12);
    for (int i = 0; i < 12; i++) begin
      check(logTid[b+i] == 2'(i % 3), "R8", "rotation order", logTid[b+i], i % 3);
      check(logPc[b+i] == 9'(base[i%3] + i/3), "R3", "per-thread address", logPc[b+i], base[i%3] + i/3);
    end
    for (int t = 0; t < NCTX; t++)
      check(doneCnt[t] == d[t] + 1, "R10", "done per thread", doneCnt[t] - d[t], 1);
    b = logN;
    doLaunch(16, acc, tid);
    check(acc && tid == 0, "R10", "freed context reused", tid, 0);
    waitLog(b + 5, 40);
    check(logN == b + 5 && logTid[b] == 0, "R10", "relaunched thread runs", logN - b, 5);
  endtask

  task automatic t_bubble();
    int b, r0, tid, idle; bit acc;
    loadWord(200, mkWord(0, OP_TEX, OP_S, 200));
    loadWord(201, mkWord(1, OP_V, OP_S, 201));
    loadWord(210, mkWord(0, OP_TEX, OP_S, 210));
    loadWord(211, mkWord(1, OP_V, OP_S, 211));
    repeat (4) @(negedge clk);
    rspLat = 8; b = logN; r0 = reqCnt;
    doLaunch(200, acc, tid);
    doLaunch(210, acc, tid);
    repeat (3) @(negedge clk);
    idle = 0;
    for (int i = 0; i < 4; i++) begin
      if (!issueValid) idle++;
      @(negedge clk);
    end
    check(idle == 4, "R9", "bubbles while all threads wait", idle, 4);
    waitLog(b + 4, 60);
    repeat (4) @(negedge clk);
    check(logN == b + 4 && reqCnt == r0 + 2, "R5", "two samples, four issues", reqCnt - r0, 2);
    check(logLast[b+2] && logLast[b+3], "R10", "both threads end", logN - b, 4);
    b = logN;
    manV = 1'b1; manT = 2'd2;
    @(negedge clk);
    manT = 2'd0;
    @(negedge clk);
    manV = 1'b0;
    repeat (6) @(negedge clk);
    check(logN == b && !issueValid, "R7", "response to free context ignored", logN - b, 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
  endtask

  initial begin
    t_reset();
    t_single();
    t_texture();
    t_scalar_tex();
    t_round_robin();
    t_bubble();
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog (R1..all): actual timeout expected completion");
    summary();
    $finish;
  end
endmodule